// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the controller side of a four-bank double data rate SDRAM command bus. On each rising clock edge it samples the chip select, row strobe, column strobe, write enable, clock enable, a 2-bit bank address and a 13-bit address. From these it produces a registered report of the command: its code, the target bank, the row, column or op code, and the A10 qualifier. It keeps its own copy of which banks hold an open row and which row that is. It raises a one-cycle error pulse whenever a command breaks the bank state rules.

The block also holds the base and extended mode registers. It derives the burst length from the base register. It uses that length to close a bank after an auto-precharge access and to watch for the clock enable dropping in the middle of a burst. When the clock enable drops, the block enters power-down and picks the power-down type from the bank state. While in power-down it ignores commands. On exit the bank state is kept as it was.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: After reset, `dec_cmd` is NOP (3'b111), `bank_act` and `pd_mode` are 0, `cmd_err` is low and both mode registers read 0.
- R2: When chip select is sampled high, the command is masked. `dec_cmd` shows NOP one cycle later and no state changes.
- R3: A live command (chip select low, clock enable high, not in power-down) is reported one cycle after sampling. `dec_cmd` = {RAS#,CAS#,WE#}, with 011 ACTIVE, 101 READ, 100 WRITE, 010 PRECHARGE, 001 AUTO REFRESH, 000 MODE SET, 110 BURST STOP and 111 NOP. `cmd_bank` reports the bank address.
- R4: ACTIVE to an idle bank sets its bit in `bank_act` (bit n = bank n). It stores the 13-bit row in `open_rows[n*13 +: 13]` and reports the row on `cmd_addr`.
- R5: READ and WRITE report the column A8:A0 on `cmd_addr` (upper bits zero) and A10 on `cmd_flag`.
- R6: A READ or WRITE to an idle bank, or an ACTIVE to a bank that is already active, pulses `cmd_err` and changes no bank state. A READ, WRITE or ACTIVE to a bank with an auto-precharge still pending does the same.
- R7: PRECHARGE with A10 low closes only the addressed bank. With A10 high it closes all banks. It never errs, and `cmd_flag` reports A10.
- R8: A READ or WRITE with A10 high closes its bank after B clocks. The bank bit is still set for B-1 cycles and is cleared from the B-th report on. B is 1, 2 or 4 when mode bits 2:0 are 001, 010 or 011, and 4 otherwise.
- R9: AUTO REFRESH or MODE SET while any bank is active pulses `cmd_err` and has no effect.
- R10: MODE SET with bank address 0 loads `mode_reg`, with bank address 1 loads `ext_mode_reg`, and with bank address bit 1 high errs and loads nothing.
- R11: Clock enable sampled low outside power-down enters power-down. `pd_mode` becomes 2'b01 with all banks idle and 2'b10 with any bank active. Commands sampled while in power-down, or on the entry edge, are reported as NOP and have no effect.
- R12: Clock enable sampled high in power-down returns `pd_mode` to 0 with `bank_act` and `open_rows` unchanged. The exit edge carries no command.
- R13: Clock enable sampled low while a read or write burst is still running (B clocks from the access) pulses `cmd_err` and power-down is not entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples everything |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | 2 | Bank address |
| addr | input | 13 | Address / op code |
| dec_cmd | output | 3 | Decoded command code |
| cmd_bank | output | 2 | Bank of the reported command |
| cmd_addr | output | 13 | Row, column or op code |
| cmd_flag | output | 1 | A10 of READ/WRITE/PRECHARGE |
| cmd_err | output | 1 | Illegal command pulse |
| bank_act | output | 4 | Open-row flag per bank |
| open_rows | output | 52 | Stored row per bank |
| pd_mode | output | 2 | 0 none, 1 precharge PD, 2 active PD |
| mode_reg | output | 13 | Base mode register |
| ext_mode_reg | output | 13 | Extended mode register |

## Verification
The bound checker tests the cycle-local rules on every cycle. It checks that masked commands and commands in power-down report NOP, that live commands echo their code, that a repeated activate errs, that precharge-all and auto refresh follow the bank state, and that power-down freezes the bank flags. Several behaviours can only be shown by the directed scenarios: the delayed close after auto-precharge, the choice of power-down type, register selection during mode set, the refusal of power-down inside a burst, and the stored row values surviving power-down.

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker #(
  parameter int AW = 13,
  parameter int CW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              cke,
  input  logic [1:0]        ba,
  input  logic [AW-1:0]     addr,
  output logic [2:0]        dec_cmd,
  output logic [1:0]        cmd_bank,
  output logic [AW-1:0]     cmd_addr,
  output logic              cmd_flag,
  output logic              cmd_err,
  output logic [3:0]        bank_act,
  output logic [4*AW-1:0]   open_rows,
  output logic [1:0]        pd_mode,
  output logic [AW-1:0]     mode_reg,
  output logic [AW-1:0]     ext_mode_reg
);
  localparam int NB = 4;
  localparam logic [2:0] C_MRS = 3'b000, C_REF = 3'b001, C_PRE = 3'b010, C_ACT = 3'b011,
                         C_WR  = 3'b100, C_RD  = 3'b101, C_BST = 3'b110, C_NOP = 3'b111;
  localparam logic [1:0] PD_NONE = 2'b00, PD_PRE = 2'b01, PD_ACT = 2'b10;

  logic [AW-1:0] rows [NB];
  logic [2:0]    ap_cnt [NB];
  logic [2:0]    burst_cnt;
  logic [2:0]    bl_clk;

  wire [2:0] raw     = {ras_n, cas_n, we_n};
  wire       live    = !cs_n && cke && (pd_mode == PD_NONE);
  wire [2:0] cmd     = live ? raw : C_NOP;
  wire       any_act = |bank_act;
  wire       pend    = ap_cnt[ba] != 3'd0;

  always_comb begin
    case (mode_reg[2:0])
      3'b001:  bl_clk = 3'd1;
      3'b010:  bl_clk = 3'd2;
      default: bl_clk = 3'd4;
    endcase
  end

  for (genvar i = 0; i < NB; i++) begin : g_rows
    assign open_rows[i*AW +: AW] = rows[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_cmd <= C_NOP; cmd_bank <= '0; cmd_addr <= '0; cmd_flag <= 1'b0; cmd_err <= 1'b0;
      bank_act <= '0; pd_mode <= PD_NONE; mode_reg <= '0; ext_mode_reg <= '0; burst_cnt <= '0;
      for (int i = 0; i < NB; i++) begin
        rows[i] <= '0; ap_cnt[i] <= '0;
      end
    end else begin
      dec_cmd <= cmd; cmd_bank <= '0; cmd_addr <= '0; cmd_flag <= 1'b0; cmd_err <= 1'b0;
      if (burst_cnt != 3'd0) burst_cnt <= burst_cnt - 3'd1;
      for (int i = 0; i < NB; i++) begin
        if (ap_cnt[i] != 3'd0) begin
          ap_cnt[i] <= ap_cnt[i] - 3'd1;
          if (ap_cnt[i] == 3'd1) bank_act[i] <= 1'b0;
        end
      end
      if (pd_mode != PD_NONE) begin
        if (cke) pd_mode <= PD_NONE;
      end else if (!cke) begin
        if (burst_cnt != 3'd0) cmd_err <= 1'b1;
        else pd_mode <= any_act ? PD_ACT : PD_PRE;
      end else if (!cs_n) begin
        cmd_bank <= ba;
        case (cmd)
          C_ACT: begin
            cmd_addr <= addr;
            if (bank_act[ba] || pend) cmd_err <= 1'b1;
            else begin
              bank_act[ba] <= 1'b1;
              rows[ba] <= addr;
            end
          end
          C_RD, C_WR: begin
            cmd_addr <= {{(AW-CW){1'b0}}, addr[CW-1:0]};
            cmd_flag <= addr[10];
            if (!bank_act[ba] || pend) cmd_err <= 1'b1;
            else begin
              burst_cnt <= bl_clk;
              if (addr[10]) ap_cnt[ba] <= bl_clk;
            end
          end
          C_PRE: begin
            cmd_flag <= addr[10];
            if (addr[10]) begin
              bank_act <= '0;
              for (int i = 0; i < NB; i++) ap_cnt[i] <= '0;
            end else begin
              bank_act[ba] <= 1'b0;
              ap_cnt[ba] <= '0;
            end
          end
          C_REF: if (any_act) cmd_err <= 1'b1;
          C_MRS: begin
            cmd_addr <= addr;
            if (any_act || ba[1]) cmd_err <= 1'b1;
            else if (ba[0]) ext_mode_reg <= addr;
            else mode_reg <= addr;
          end
          C_BST: burst_cnt <= '0;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       ras_n,
  input logic       cas_n,
  input logic       we_n,
  input logic       cke,
  input logic [1:0] ba,
  input logic       a10,
  input logic [2:0] dec_cmd,
  input logic       cmd_err,
  input logic [3:0] bank_act,
  input logic [1:0] pd_mode
);
  wire live = !cs_n && cke && (pd_mode == 2'b00);

  // R2
  masked_nop_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |=> dec_cmd == 3'b111);
  // R11
  pd_nop_chk: assert property (@(posedge clk) disable iff (!rst_n) (pd_mode != 2'b00) |=> dec_cmd == 3'b111);
  // R3
  echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live |=> dec_cmd == $past({ras_n, cas_n, we_n}));
  // R6
  dup_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && ({ras_n, cas_n, we_n} == 3'b011) && bank_act[ba] |=> cmd_err);
  // R7
  pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && ({ras_n, cas_n, we_n} == 3'b010) && a10 |=> bank_act == 4'b0000);
  // R9
  ref_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live && ({ras_n, cas_n, we_n} == 3'b001) && (bank_act != 4'b0000) |=> cmd_err);
  // R12
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_mode != 2'b00) |=> $stable(bank_act));
endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .cke(cke), .ba(ba), .a10(addr[10]), .dec_cmd(dec_cmd), .cmd_err(cmd_err),
  .bank_act(bank_act), .pd_mode(pd_mode)
);

// File: tb/sdram_cmd_tracker_tb.sv
module sdram_cmd_tracker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
  logic [1:0] ba = '0;
  logic [12:0] addr = '0;
  logic [2:0] dec_cmd;
  logic [1:0] cmd_bank;
  logic [12:0] cmd_addr;
  logic cmd_flag, cmd_err;
  logic [3:0] bank_act;
  logic [51:0] open_rows;
  logic [1:0] pd_mode;
  logic [12:0] mode_reg, ext_mode_reg;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  sdram_cmd_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cke(cke), .ba(ba), .addr(addr), .dec_cmd(dec_cmd), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .cmd_flag(cmd_flag), .cmd_err(cmd_err), .bank_act(bank_act),
    .open_rows(open_rows), .pd_mode(pd_mode), .mode_reg(mode_reg), .ext_mode_reg(ext_mode_reg)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(logic c, logic [2:0] k, logic [1:0] b, logic [12:0] a, logic e = 1'b1);
    @(negedge clk);
    cs_n = c; {ras_n, cas_n, we_n} = k; ba = b; addr = a; cke = e;
    @(posedge clk); #1;
  endtask

  task automatic nop(logic e = 1'b1);
    issue(1'b0, 3'b111, 2'd0, 13'd0, e);
  endtask

  task automatic t_reset;
    check("R1 cmd", dec_cmd, 3'b111);
    check("R1 act", bank_act, 0);
    check("R1 pd", pd_mode, 0);
    check("R1 err", cmd_err, 0);
    check("R1 mr", {mode_reg, ext_mode_reg}, 0);
  endtask

  task automatic t_mode;
    issue(0, 3'b000, 2'd0, 13'h0022);
    check("R10 base", mode_reg, 13'h0022);
    check("R3 mrs code", dec_cmd, 3'b000);
    issue(0, 3'b000, 2'd1, 13'h0005);
    check("R10 ext", ext_mode_reg, 13'h0005);
    check("R10 base kept", mode_reg, 13'h0022);
    issue(0, 3'b000, 2'd2, 13'h1111);
    check("R10 bad bank err", cmd_err, 1);
    check("R10 regs kept", {mode_reg, ext_mode_reg}, {13'h0022, 13'h0005});
  endtask

  task automatic t_mask;
    issue(1, 3'b011, 2'd1, 13'h0abc);
    check("R2 nop", dec_cmd, 3'b111);
    check("R2 no open", bank_act, 0);
  endtask

  task automatic t_act;
    issue(0, 3'b011, 2'd2, 13'h1abc);
    check("R3 code", dec_cmd, 3'b011);
    check("R3 bank", cmd_bank, 2);
    check("R4 row out", cmd_addr, 13'h1abc);
    check("R4 open", bank_act, 4'b0100);
    check("R4 row store", open_rows[2*13 +: 13], 13'h1abc);
    issue(0, 3'b011, 2'd2, 13'h0123);
    check("R6 dup act err", cmd_err, 1);
    check("R6 row kept", open_rows[2*13 +: 13], 13'h1abc);
    issue(0, 3'b000, 2'd0, 13'h0033);
    check("R9 mrs busy err", cmd_err, 1);
    check("R9 mrs no load", mode_reg, 13'h0022);
  endtask

  task automatic t_rdwr;
    issue(0, 3'b101, 2'd2, 13'h1bff);
    check("R5 col", cmd_addr, 13'h01ff);
    check("R5 flag", cmd_flag, 0);
    check("R5 no err", cmd_err, 0);
    issue(0, 3'b100, 2'd0, 13'h0001);
    check("R6 idle wr err", cmd_err, 1);
    check("R6 state kept", bank_act, 4'b0100);
    nop(); nop();
  endtask

  task automatic t_ap;
    issue(0, 3'b100, 2'd2, 13'h0405);
    check("R5 ap flag", cmd_flag, 1);
    check("R8 still open", bank_act, 4'b0100);
    issue(0, 3'b101, 2'd2, 13'h0001);
    check("R6 pending err", cmd_err, 1);
    check("R8 open B-1", bank_act, 4'b0100);
    nop();
    check("R8 closed", bank_act, 4'b0000);
  endtask

  task automatic t_pre;
    issue(0, 3'b011, 2'd0, 13'h0010);
    issue(0, 3'b011, 2'd1, 13'h0011);
    issue(0, 3'b011, 2'd3, 13'h0013);
    issue(0, 3'b010, 2'd1, 13'h0000);
    check("R7 single", bank_act, 4'b1001);
    check("R7 flag low", cmd_flag, 0);
    issue(0, 3'b010, 2'd0, 13'h0400);
    check("R7 all", bank_act, 4'b0000);
    check("R7 flag high", cmd_flag, 1);
  endtask

  task automatic t_ref;
    issue(0, 3'b011, 2'd3, 13'h0007);
    issue(0, 3'b001, 2'd0, 13'h0000);
    check("R9 ref busy err", cmd_err, 1);
    issue(0, 3'b010, 2'd0, 13'h0400);
    issue(0, 3'b001, 2'd0, 13'h0000);
    check("R9 ref ok", {dec_cmd, cmd_err}, {3'b001, 1'b0});
  endtask

  task automatic t_pd;
    issue(0, 3'b011, 2'd1, 13'h0aaa);
    nop(1'b0);
    check("R11 active pd", pd_mode, 2'b10);
    issue(0, 3'b011, 2'd0, 13'h0bbb, 1'b0);
    check("R11 ignored cmd", dec_cmd, 3'b111);
    check("R11 ignored state", bank_act, 4'b0010);
    issue(0, 3'b011, 2'd0, 13'h0bbb, 1'b1);
    check("R12 exit", pd_mode, 0);
    check("R12 banks kept", bank_act, 4'b0010);
    check("R12 row kept", open_rows[1*13 +: 13], 13'h0aaa);
    issue(0, 3'b010, 2'd0, 13'h0400);
    nop(1'b0);
    check("R11 precharge pd", pd_mode, 2'b01);
    nop();
    check("R12 exit idle", pd_mode, 0);
  endtask

  task automatic t_cke_burst;
    issue(0, 3'b011, 2'd0, 13'h0001);
    issue(0, 3'b101, 2'd0, 13'h0002);
    nop(1'b0);
    check("R13 err", cmd_err, 1);
    check("R13 no pd", pd_mode, 0);
    nop(); nop();
    issue(0, 3'b010, 2'd0, 13'h0400);
  endtask

  initial begin
    #4000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    t_reset();
    t_mode();
    t_mask();
    t_act();
    t_rdwr();
    t_ap();
    t_pre();
    t_ref();
    t_pd();
    t_cke_burst();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule